// File: doc/BRIEF.md
# Video Input Merge with Lock and Failure Diagnostics

This block places a pixel stream onto a raster that a separate timing generator produces. The pixel stream arrives as an AXI4-Stream with a start-of-frame flag on `tuser` and an end-of-line flag on `tlast`. The raster arrives as three flags: frame start, line start and active. The stream and the raster share one clock. While the stream is aligned with the raster, pixels go straight through to the output. If the stream is missing, stalls or has the wrong shape, the output is filled from a fallback source. That source is either a programmable black level for each colour plane, or a repeat of the last good pixel.

The block gains lock when a start-of-frame beat meets the raster's frame start. It loses lock on the first stall or size mismatch. After a loss it throws away stream beats until the next start-of-frame beat, then holds that beat until the raster reaches its next frame start.

Three event counters are kept: locked frames, size errors and stalls. The block also measures the width and height of the incoming frames and the number of clocks from one input frame to the next.

Top module: `vidMerge`

## Requirements
- R1: After reset, `outData`, `outValid`, `locked`, all three counters and all three measurements are zero.
- R2: While unlocked, a beat with `inTuser`=1 is held with `inTready`=0 until a cycle with `refSof`=1 and `refActive`=1. Beats with `inTuser`=0 are accepted and discarded. Lock is gained in the cycle where the held beat is accepted, and that beat's pixel is passed through.
- R3: While locked, `inTready` equals `refActive` and each active beat is passed through. `outData` and `outValid` are registered: `outValid` is `refActive` delayed by one clock. The output is the black level whenever `outValid` is 0.
- R4: A locked active cycle with `inTvalid`=0 is a stall. It adds one to `stallCount`, drops lock, and outputs the fill value for that cycle.
- R5: A locked active beat is a size error if `inTuser` differs from `refSof`, or if `refSol` differs from the `inTlast` of the previous passed beat. A size error adds one to `sizeErrCount`, drops lock, and outputs the fill value.
- R6: The fill value depends on `fallbackRepeat`. When it is 0, the fill value is the black level: plane p is taken from `blackLevel[p*BPS +: BPS]`. When it is 1, the fill value is the last pixel that was passed through.
- R7: `lockedCount` increases by one for each frame-start cycle whose pixel is passed through.
- R8: `measWidth` holds the beat count of the most recent line, counted from the line's first beat up to and including its `tlast` beat.
- R9: `measHeight` holds the number of `tlast` beats between the two most recent accepted start-of-frame beats.
- R10: `clksPerFrame` holds the number of clocks between the two most recent accepted start-of-frame beats.
- R11: `locked` is 1 exactly while the merge is aligned to the raster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for the stream and the raster |
| rstN | input | 1 | Asynchronous reset, active low |
| inTdata | input | BPS*PLANES | Stream pixel, plane p at bits [p*BPS +: BPS] |
| inTvalid | input | 1 | Stream valid |
| inTuser | input | 1 | Start-of-frame flag on the stream |
| inTlast | input | 1 | End-of-line flag on the stream |
| inTready | output | 1 | Stream ready |
| refSof | input | 1 | Raster frame start, asserted on the first active pixel |
| refSol | input | 1 | Raster line start, asserted on each line's first active pixel |
| refActive | input | 1 | Raster active-picture flag |
| blackLevel | input | BPS*PLANES | Black value for each plane |
| fallbackRepeat | input | 1 | Fill policy: 0 = black, 1 = repeat last good pixel |
| outData | output | BPS*PLANES | Merged pixel |
| outValid | output | 1 | Merged pixel lies in the active picture |
| locked | output | 1 | Merge status: aligned to the raster |
| measWidth | output | HW | Measured line width |
| measHeight | output | VW | Measured frame height |
| clksPerFrame | output | CLKW | Clocks per input frame |
| lockedCount | output | CNTW | Locked-frame counter |
| sizeErrCount | output | CNTW | Size-error counter |
| stallCount | output | CNTW | Stall counter |

## Verification
The bench first keeps a start-of-frame beat waiting before the raster starts. A design that leaked that beat early would start out misaligned.

It then drops one beat in the middle of a frame, under each fill policy. A wrong design would keep passing pixels shifted by one position, or would fill with the wrong value.

It also sends a frame with one short line. The next beat then lands where the raster is still mid-line. A design that only checked `tuser` would miss this error and stay locked with the pixels displaced.

After each damaged frame, the bench checks that lock comes back on the next frame start and that the counters and measurements hold the expected values. Width, height and frame period must survive the discarded beats.

// File: rtl/vmPkg.sv
package vmPkg;
  // Strobes from the control to the pixel path, one cycle's worth
  typedef struct packed {
    logic live;         // current beat is aligned and passed through
    logic lockedFrame;  // live beat at raster frame start
    logic stall;        // locked active cycle without data
    logic sizeErr;      // locked beat out of place on the raster
    logic accept;       // stream handshake this cycle
  } vmStrobe_t;

  typedef enum logic {
    MERGE_HUNT   = 1'b0,
    MERGE_LOCKED = 1'b1
  } vmState_e;
endpackage

// File: rtl/vmCtrl.sv
module vmCtrl
  import vmPkg::*;
#(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inTvalid,
  input  logic            inTuser,
  input  logic            inTlast,
  input  logic            refSof,
  input  logic            refSol,
  input  logic            refActive,
  output logic            inTready,
  output logic            locked,
  output vmStrobe_t       strb,
  output logic [CNTW-1:0] lockedCount,
  output logic [CNTW-1:0] sizeErrCount,
  output logic [CNTW-1:0] stallCount
);
  vmState_e stateQ;
  logic     prevLastQ;
  logic     frameStart;
  logic     acquire;
  logic     checkBeat;
  logic     sizeErrNow;
  logic     stallNow;

  always_comb begin
    frameStart = refSof && refActive;
    acquire    = (stateQ == MERGE_HUNT) && frameStart && inTvalid && inTuser;
    checkBeat  = (stateQ == MERGE_LOCKED) && refActive && inTvalid;
    stallNow   = (stateQ == MERGE_LOCKED) && refActive && !inTvalid;
    sizeErrNow = checkBeat && ((refSol != prevLastQ) || (inTuser != refSof));
    if (stateQ == MERGE_LOCKED) inTready = refActive;
    else                        inTready = inTvalid && (!inTuser || frameStart);
    strb.accept      = inTvalid && inTready;
    strb.live        = acquire || (checkBeat && !sizeErrNow);
    strb.lockedFrame = frameStart && strb.live;
    strb.stall       = stallNow;
    strb.sizeErr     = sizeErrNow;
  end

  assign locked = (stateQ == MERGE_LOCKED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= MERGE_HUNT;
      prevLastQ <= 1'b0;
    end else begin
      if (acquire) stateQ <= MERGE_LOCKED;
      else if (stallNow || sizeErrNow) stateQ <= MERGE_HUNT;
      if (strb.live) prevLastQ <= inTlast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockedCount  <= '0;
      sizeErrCount <= '0;
      stallCount   <= '0;
    end else begin
      if (strb.lockedFrame) lockedCount  <= lockedCount + CNTW'(1);
      if (sizeErrNow)       sizeErrCount <= sizeErrCount + CNTW'(1);
      if (stallNow)         stallCount   <= stallCount + CNTW'(1);
    end
  end

  // R4
  stall_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stall |=> stallCount == $past(stallCount) + CNTW'(1));
  // R5
  size_err_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sizeErr |=> sizeErrCount == $past(sizeErrCount) + CNTW'(1));
  // R11
  lock_lost_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stall || strb.sizeErr) |=> !locked);
  // R7
  locked_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lockedFrame |=> lockedCount == $past(lockedCount) + CNTW'(1));
  // R2
  hunt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && inTvalid && inTuser && !refSof) |-> !strb.accept);
endmodule

// File: rtl/vmPixPath.sv
module vmPixPath
  import vmPkg::*;
#(
  parameter int BPS    = 8,
  parameter int PLANES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BPS*PLANES-1:0] inTdata,
  input  logic [BPS*PLANES-1:0] blackLevel,
  input  logic                  fallbackRepeat,
  input  logic                  refActive,
  input  vmStrobe_t             strb,
  output logic [BPS*PLANES-1:0] outData,
  output logic                  outValid
);
  localparam int PW = BPS * PLANES;

  logic [PW-1:0] lastGoodQ;
  logic [PW-1:0] fillPix;
  logic [PW-1:0] nextPix;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign fillPix[p*BPS +: BPS] = fallbackRepeat ? lastGoodQ[p*BPS +: BPS]
                                                  : blackLevel[p*BPS +: BPS];
  end

  always_comb begin
    if (!refActive)     nextPix = blackLevel;
    else if (strb.live) nextPix = inTdata;
    else                nextPix = fillPix;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData   <= '0;
      outValid  <= 1'b0;
      lastGoodQ <= '0;
    end else begin
      outData  <= nextPix;
      outValid <= refActive;
      if (strb.live) lastGoodQ <= inTdata;
    end
  end

  // R3
  live_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.live || strb.lockedFrame) |=> outData == $past(inTdata));
  // R3
  live_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.live |-> strb.accept);
  // R6
  black_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refActive && !strb.live && !fallbackRepeat) |=> outData == $past(blackLevel));
  // R6
  repeat_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.stall || strb.sizeErr) && fallbackRepeat) |=> outData == $past(lastGoodQ));
  // R3
  blank_black_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refActive |=> (!outValid && outData == $past(blackLevel)));
endmodule

// File: rtl/vmMeasure.sv
module vmMeasure #(
  parameter int HW   = 12,
  parameter int VW   = 12,
  parameter int CLKW = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accept,
  input  logic            inTuser,
  input  logic            inTlast,
  output logic [HW-1:0]   measWidth,
  output logic [VW-1:0]   measHeight,
  output logic [CLKW-1:0] clksPerFrame
);
  logic [HW-1:0]   pixCnt;
  logic [VW-1:0]   lineCnt;
  logic [CLKW-1:0] clkCnt;
  logic            seenSofQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt       <= '0;
      lineCnt      <= '0;
      clkCnt       <= '0;
      seenSofQ     <= 1'b0;
      measWidth    <= '0;
      measHeight   <= '0;
      clksPerFrame <= '0;
    end else begin
      if (clkCnt != '1) clkCnt <= clkCnt + CLKW'(1);
      if (accept) begin
        if (inTlast) begin
          measWidth <= inTuser ? HW'(1) : pixCnt + HW'(1);
          pixCnt    <= '0;
        end else begin
          pixCnt <= inTuser ? HW'(1) : pixCnt + HW'(1);
        end
        if (inTuser) begin
          seenSofQ <= 1'b1;
          clkCnt   <= CLKW'(1);
          if (seenSofQ) begin
            measHeight   <= lineCnt;
            clksPerFrame <= clkCnt;
          end
          lineCnt <= inTlast ? VW'(1) : '0;
        end else if (inTlast) begin
          lineCnt <= lineCnt + VW'(1);
        end
      end
    end
  end

  // R8
  width_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inTlast) |=> measWidth != '0);
  // R10
  frame_clks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inTuser && seenSofQ) |=> clksPerFrame != '0);
endmodule

// File: rtl/vidMerge.sv
module vidMerge
  import vmPkg::*;
#(
  parameter int BPS    = 8,
  parameter int PLANES = 3,
  parameter int HW     = 12,
  parameter int VW     = 12,
  parameter int CLKW   = 24,
  parameter int CNTW   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BPS*PLANES-1:0] inTdata,
  input  logic                  inTvalid,
  input  logic                  inTuser,
  input  logic                  inTlast,
  output logic                  inTready,
  input  logic                  refSof,
  input  logic                  refSol,
  input  logic                  refActive,
  input  logic [BPS*PLANES-1:0] blackLevel,
  input  logic                  fallbackRepeat,
  output logic [BPS*PLANES-1:0] outData,
  output logic                  outValid,
  output logic                  locked,
  output logic [HW-1:0]         measWidth,
  output logic [VW-1:0]         measHeight,
  output logic [CLKW-1:0]       clksPerFrame,
  output logic [CNTW-1:0]       lockedCount,
  output logic [CNTW-1:0]       sizeErrCount,
  output logic [CNTW-1:0]       stallCount
);
  vmStrobe_t strb;

  vmCtrl #(.CNTW(CNTW)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .inTvalid(inTvalid), .inTuser(inTuser), .inTlast(inTlast),
    .refSof(refSof), .refSol(refSol), .refActive(refActive),
    .inTready(inTready), .locked(locked), .strb(strb),
    .lockedCount(lockedCount), .sizeErrCount(sizeErrCount), .stallCount(stallCount)
  );

  vmPixPath #(.BPS(BPS), .PLANES(PLANES)) i_pix (
    .clk(clk), .rstN(rstN),
    .inTdata(inTdata), .blackLevel(blackLevel), .fallbackRepeat(fallbackRepeat),
    .refActive(refActive), .strb(strb),
    .outData(outData), .outValid(outValid)
  );

  vmMeasure #(.HW(HW), .VW(VW), .CLKW(CLKW)) i_meas (
    .clk(clk), .rstN(rstN),
    .accept(strb.accept), .inTuser(inTuser), .inTlast(inTlast),
    .measWidth(measWidth), .measHeight(measHeight), .clksPerFrame(clksPerFrame)
  );
endmodule

// File: tb/test_vidMerge.sv
`timescale 1ns/1ps
module test_vidMerge;
  localparam int BPS = 8, PLANES = 3, PW = BPS * PLANES;
  localparam int HW = 12, VW = 12, CLKW = 24, CNTW = 16;
  localparam int W = 8, H = 4, LT = 12, VB = 2;
  localparam logic [PW-1:0] BLACK = 24'h80_80_10;
  localparam int K_NORM = 0, K_STALL = 1, K_SHORT = 2;

  typedef struct packed { logic [PW-1:0] d; logic u; logic l; } beat_t;
  typedef struct { logic [PW-1:0] v; string r; } exp_t;

  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;

  logic [PW-1:0]   inTdata = '0;
  logic            inTvalid = 1'b0, inTuser = 1'b0, inTlast = 1'b0, inTready;
  logic            refSof = 1'b0, refSol = 1'b0, refActive = 1'b0;
  logic            fallbackRepeat = 1'b0;
  logic [PW-1:0]   outData;
  logic            outValid, locked;
  logic [HW-1:0]   measWidth;
  logic [VW-1:0]   measHeight;
  logic [CLKW-1:0] clksPerFrame;
  logic [CNTW-1:0] lockedCount, sizeErrCount, stallCount;

  vidMerge #(.BPS(BPS), .PLANES(PLANES), .HW(HW), .VW(VW), .CLKW(CLKW), .CNTW(CNTW)) i_vidMerge (
    .clk(clk), .rstN(rstN), .inTdata(inTdata), .inTvalid(inTvalid), .inTuser(inTuser),
    .inTlast(inTlast), .inTready(inTready), .refSof(refSof), .refSol(refSol),
    .refActive(refActive), .blackLevel(BLACK), .fallbackRepeat(fallbackRepeat),
    .outData(outData), .outValid(outValid), .locked(locked), .measWidth(measWidth),
    .measHeight(measHeight), .clksPerFrame(clksPerFrame), .lockedCount(lockedCount),
    .sizeErrCount(sizeErrCount), .stallCount(stallCount)
  );

  int nChecks = 0, nFail = 0;
  beat_t srcQ[$];
  exp_t  expQ[$];
  logic  hsQ = 1'b0;
  logic  done = 1'b0;

  always @(posedge clk) hsQ <= inTvalid && inTready;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pixVal(int f, int y, int x);
    return {8'(f + 1), 8'(y), 8'(x)};
  endfunction

  // Scoreboard monitor: one expected item per active raster cycle
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      if (expQ.size() == 0) check("R3 unexpected output", 32'(outData), 32'hFFFF_FFFF);
      else begin
        exp_t e;
        e = expQ.pop_front();
        check(e.r, 32'(outData), 32'(e.v));
      end
    end
  end

  task automatic tick(logic act, logic sol, logic sof, logic gap);
    @(negedge clk);
    if (hsQ) void'(srcQ.pop_front());
    refActive = act; refSol = sol; refSof = sof;
    if (srcQ.size() > 0 && !gap) begin
      inTvalid = 1'b1; inTdata = srcQ[0].d; inTuser = srcQ[0].u; inTlast = srcQ[0].l;
    end else begin
      inTvalid = 1'b0; inTuser = 1'b0; inTlast = 1'b0;
    end
  endtask

  task automatic pushFrame(int f, int kind, int ey);
    for (int y = 0; y < H; y++) begin
      int n;
      n = (kind == K_SHORT && y == ey) ? W - 1 : W;
      for (int x = 0; x < n; x++) begin
        beat_t b;
        b.d = pixVal(f, y, x); b.u = (x == 0 && y == 0); b.l = (x == n - 1);
        srcQ.push_back(b);
      end
    end
  endtask

  task automatic runFrame(int f, int kind, int ey, int ex, logic fb);
    logic          damaged;
    logic [PW-1:0] lastVal;
    damaged = 1'b0; lastVal = '0;
    fallbackRepeat = fb;
    pushFrame(f, kind, ey);
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < LT; x++) begin
        logic act, gap, ev;
        act = (x < W);
        gap = (kind == K_STALL && y == ey && x == ex);
        ev  = gap || (kind == K_SHORT && y == ey && x == W - 1);
        if (act) begin
          exp_t e;
          if (ev) damaged = 1'b1;
          if (damaged) begin
            e.v = fb ? lastVal : BLACK;
            e.r = (kind == K_STALL) ? (fb ? "R4 R6 repeat fill" : "R4 R6 black fill")
                                    : "R5 R6 black fill";
          end else begin
            e.v = pixVal(f, y, x); e.r = (f == 0 && y == 0 && x == 0) ? "R2 acquire pixel" : "R3 pass";
            lastVal = e.v;
          end
          expQ.push_back(e);
        end
        tick(act, act && x == 0, act && x == 0 && y == 0, gap);
      end
    end
    for (int i = 0; i < VB * LT; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 outData", 32'(outData), 0);
    check("R1 outValid", 32'(outValid), 0);
    check("R1 locked", 32'(locked), 0);
    check("R1 counters", 32'(lockedCount) + 32'(sizeErrCount) + 32'(stallCount), 0);
    check("R1 measurements", 32'(measWidth) + 32'(measHeight) + 32'(clksPerFrame), 0);
    rstN = 1'b1;

    // R2: start-of-frame beat waits while the raster is idle
    pushFrame(0, K_NORM, 0);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    check("R2 held sof valid", 32'(inTvalid), 1);
    check("R2 held sof ready", 32'(inTready), 0);
    srcQ.delete();

    runFrame(0, K_NORM, 0, 0, 1'b0);
    check("R11 locked after aligned frame", 32'(locked), 1);
    check("R3 blanking black data", 32'(outData), 32'(BLACK));
    check("R3 blanking valid low", 32'(outValid), 0);
    runFrame(1, K_NORM, 0, 0, 1'b0);
    check("R7 locked count", 32'(lockedCount), 2);
    check("R8 width", 32'(measWidth), W);
    check("R9 height", 32'(measHeight), H);
    check("R10 clocks per frame", 32'(clksPerFrame), LT * (H + VB));

    runFrame(2, K_STALL, 1, 3, 1'b0);
    check("R4 stall count", 32'(stallCount), 1);
    check("R11 unlocked after stall", 32'(locked), 0);
    runFrame(3, K_NORM, 0, 0, 1'b0);
    check("R11 relocked", 32'(locked), 1);

    runFrame(4, K_STALL, 2, 5, 1'b1);
    check("R4 stall count repeat mode", 32'(stallCount), 2);
    runFrame(5, K_NORM, 0, 0, 1'b1);

    runFrame(6, K_SHORT, 1, 0, 1'b0);
    check("R5 size error count", 32'(sizeErrCount), 1);
    check("R11 unlocked after size error", 32'(locked), 0);
    runFrame(7, K_NORM, 0, 0, 1'b0);
    check("R7 locked count final", 32'(lockedCount), 8);
    check("R9 height after short frame", 32'(measHeight), H);
    check("R10 clocks after short frame", 32'(clksPerFrame), LT * (H + VB));
    check("R4 stall count final", 32'(stallCount), 2);
    check("R3 scoreboard drained", 32'(expQ.size()), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule